// File: doc/BRIEF.md
# Ethernet Transmit Control Register Unit

This unit sits between a processor's register port and the transmit side of a 10/100 Ethernet MAC. It holds a PHY power-down register and a transmit control register. Processor writes become either steady control levels or self-clearing actions. The levels cover transmitter reset, random-counter reset, transmit enable, late-alarm enable and the power-down bit of each PHY. The actions are a control-frame send request, a transmit abort, a FIFO read-pointer rewind and a full FIFO pointer clear.

The control-frame request stays raised until the transmitter acknowledges it. The abort crosses into the transmit clock domain through a toggle handshake and drives the abort line for exactly two transmit clocks. The FIFO strobes are one processor-clock pulses. Reads return the stored levels. A self-clearing bit reads as 1 only while its action is still outstanding.

Top module: `txctl_regs`

## Requirements
- R1: After reset, `phy_pdn` is 2'b10, every transmit control output is 0, the power-down register reads 0x2 and the control register reads 0.
- R2: A write to word address 0 loads `phy_pdn` from data bits 1:0. That register reads back those two bits, with bits 31:2 always 0.
- R3: A write to word address 1 loads four levels: bit 15 drives `tx_reset`, bit 14 drives `rand_reset`, bit 5 is the transmit enable and bit 4 drives `late_enable`. All four read back at the same positions. `tx_enable` is the enable level forced to 0 while bit 15 is 1.
- R4: Writing 1 to bit 3 of address 1 raises `ctl_req` on the next clock. It stays high, and reads back as 1 in bit 3, until a cycle with `ctl_ack` high. After that cycle it is 0.
- R5: Writing 1 to bit 2 of address 1 makes `tx_abort` high for exactly two consecutive `tx_clk` cycles, once. Bit 2 reads back 1 from the clock after the write until the transmit side has reported completion.
- R6: A write of 1 to bit 2 while an abort is still outstanding produces no extra abort pulse.
- R7: Writing 1 to bit 1 of address 1 makes `fifo_rd_rewind` high for exactly one clock after the write. Bit 0 does the same for `fifo_clr`. Either or both may be set in one write.
- R8: Writes to any other address change no output and no register, and reads of any other address return 0.
- R9: Writing 0 to bits 3:0 of address 1 starts no action and leaves an outstanding request as it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| tx_clk | input | 1 | Transmit clock |
| wr_en | input | 1 | Single-cycle write strobe |
| addr | input | 4 | Word address for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| ctl_ack | input | 1 | Transmitter has taken the control-frame request |
| phy_pdn | output | 2 | Power-down level per PHY, 1 = powered down |
| tx_reset | output | 1 | Transmitter reset level |
| rand_reset | output | 1 | Random backoff counter reset level |
| tx_enable | output | 1 | Frame start allowed |
| late_enable | output | 1 | Late-transmit alarm timer enable |
| ctl_req | output | 1 | Control-frame send request, pending until acknowledged |
| tx_abort | output | 1 | Abort strobe in the `tx_clk` domain |
| fifo_rd_rewind | output | 1 | One-cycle pulse that rewinds the FIFO read pointer |
| fifo_clr | output | 1 | One-cycle pulse that clears both FIFO pointers |

## Verification
Levels, `ctl_req` and the FIFO strobes change on the first `clk` edge after the write cycle. The bench drives on falling edges and compares at the next falling edge. For the FIFO strobes it checks once more a cycle later to confirm each pulse has ended. The abort has a variable delay across the domain crossing, so a monitor on `tx_clk` counts pulses and their lengths. The bench reads that count after a window far longer than the two-flop synchronizers plus the pulse, and confirms the pending bit has cleared in that same window. Each mode is swept over every combination of its bits.

// File: rtl/txc_pkg.sv
package txc_pkg;
  // Bit positions in the transmit control word
  localparam int BIT_TXRST  = 15;
  localparam int BIT_RNDRST = 14;
  localparam int BIT_TXEN   = 5;
  localparam int BIT_LATE   = 4;
  localparam int BIT_CFREQ  = 3;
  localparam int BIT_ABORT  = 2;
  localparam int BIT_REWIND = 1;
  localparam int BIT_FCLR   = 0;

  localparam int          NUM_PHY    = 2;
  localparam logic [1:0]  PDN_RESET  = 2'b10;
  localparam int          ABORT_CYC  = 2;

  typedef struct packed {
    logic txrst;
    logic rndrst;
    logic txen;
    logic late;
  } lvl_t;
endpackage

// File: rtl/txc_rst_sync.sv
module txc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/txc_sync2.sv
module txc_sync2 #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] s1_q, s2_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q[i] <= 1'b0;
        s2_q[i] <= 1'b0;
      end else begin
        s1_q[i] <= d[i];
        s2_q[i] <= s1_q[i];
      end
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/txc_abort_xfer.sv
module txc_abort_xfer
  import txc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tx_clk,
  input  logic tx_rst_n,
  input  logic start,
  output logic busy,
  output logic tx_abort
);
  localparam int CNT_W = $clog2(ABORT_CYC + 1);

  // Processor side: request toggle, acknowledge synchronized back
  logic req_q, req_d;
  logic ack_q, ack_d;
  logic ack_s;

  always_comb req_d = req_q ^ start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  txc_sync2 #(.WIDTH(1)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .d(ack_q), .q(ack_s)
  );

  assign busy = req_q ^ ack_s;

  // Transmit side: detect toggle, stretch to ABORT_CYC cycles, return ack
  logic             req_s;
  logic             seen_q, seen_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             new_req;

  txc_sync2 #(.WIDTH(1)) u_req_sync (
    .clk(tx_clk), .rst_n(tx_rst_n), .d(req_q), .q(req_s)
  );

  always_comb begin
    new_req = req_s ^ seen_q;
    seen_d  = req_s;
    if (new_req)              cnt_d = CNT_W'(ABORT_CYC);
    else if (cnt_q != '0)     cnt_d = cnt_q - 1'b1;
    else                      cnt_d = cnt_q;
    ack_d   = ack_q ^ (cnt_q == CNT_W'(1));
  end

  always_ff @(posedge tx_clk or negedge tx_rst_n) begin
    if (!tx_rst_n) begin
      seen_q <= 1'b0;
      cnt_q  <= '0;
      ack_q  <= 1'b0;
    end else begin
      seen_q <= seen_d;
      cnt_q  <= cnt_d;
      ack_q  <= ack_d;
    end
  end

  assign tx_abort = (cnt_q != '0);

  // R5: pulse is at least two cycles wide
  p_abort_min_r5: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
    $rose(tx_abort) |=> tx_abort);
  // R5: pulse never exceeds two cycles
  p_abort_max_r5: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
    (tx_abort && $past(tx_abort)) |=> !tx_abort);
  // R5: pending state only begins from an accepted request
  p_busy_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

// File: rtl/txc_cpu_regs.sv
module txc_cpu_regs
  import txc_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int ADDR_PDN = 0,
  parameter int ADDR_CTL = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              ctl_ack,
  input  logic              abort_busy,
  output logic              abort_start,
  output logic [NUM_PHY-1:0] phy_pdn,
  output lvl_t              lvl,
  output logic              ctl_req,
  output logic              fifo_rd_rewind,
  output logic              fifo_clr
);
  logic wr_pdn, wr_ctl, sel_pdn, sel_ctl;

  logic [NUM_PHY-1:0] pdn_q, pdn_d;
  lvl_t               lvl_q, lvl_d;
  logic               cfr_q, cfr_d;
  logic               rew_q, rew_d;
  logic               clr_q, clr_d;
  logic               pdn_en, lvl_en;

  logic unused_wdata;
  assign unused_wdata = ^{wdata[DATA_W-1:BIT_TXRST+1], wdata[BIT_RNDRST-1:BIT_TXEN+1]};

  always_comb begin
    sel_pdn = (addr == ADDR_W'(ADDR_PDN));
    sel_ctl = (addr == ADDR_W'(ADDR_CTL));
    wr_pdn  = wr_en && sel_pdn;
    wr_ctl  = wr_en && sel_ctl;
    pdn_en  = wr_pdn;
    lvl_en  = wr_ctl;

    pdn_d        = wdata[NUM_PHY-1:0];
    lvl_d.txrst  = wdata[BIT_TXRST];
    lvl_d.rndrst = wdata[BIT_RNDRST];
    lvl_d.txen   = wdata[BIT_TXEN];
    lvl_d.late   = wdata[BIT_LATE];

    if (wr_ctl && wdata[BIT_CFREQ]) cfr_d = 1'b1;
    else if (ctl_ack)               cfr_d = 1'b0;
    else                            cfr_d = cfr_q;

    rew_d       = wr_ctl && wdata[BIT_REWIND];
    clr_d       = wr_ctl && wdata[BIT_FCLR];
    abort_start = wr_ctl && wdata[BIT_ABORT] && !abort_busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pdn_q <= PDN_RESET;
      lvl_q <= '0;
      cfr_q <= 1'b0;
      rew_q <= 1'b0;
      clr_q <= 1'b0;
    end else begin
      if (pdn_en) pdn_q <= pdn_d;
      if (lvl_en) lvl_q <= lvl_d;
      cfr_q <= cfr_d;
      rew_q <= rew_d;
      clr_q <= clr_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (sel_pdn) begin
      rdata[NUM_PHY-1:0] = pdn_q;
    end else if (sel_ctl) begin
      rdata[BIT_TXRST]  = lvl_q.txrst;
      rdata[BIT_RNDRST] = lvl_q.rndrst;
      rdata[BIT_TXEN]   = lvl_q.txen;
      rdata[BIT_LATE]   = lvl_q.late;
      rdata[BIT_CFREQ]  = cfr_q;
      rdata[BIT_ABORT]  = abort_busy;
      rdata[BIT_REWIND] = rew_q;
      rdata[BIT_FCLR]   = clr_q;
    end
  end

  assign phy_pdn        = pdn_q;
  assign lvl            = lvl_q;
  assign ctl_req        = cfr_q;
  assign fifo_rd_rewind = rew_q;
  assign fifo_clr       = clr_q;

  // R4: request only drops after an acknowledge
  p_cfreq_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl_req) |-> $past(ctl_ack));
  // R7: rewind pulse traces back to a matching write
  p_rewind_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd_rewind |-> $past(wr_en && addr == ADDR_W'(ADDR_CTL) && wdata[BIT_REWIND]));
  // R7: clear pulse traces back to a matching write
  p_clr_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |-> $past(wr_en && addr == ADDR_W'(ADDR_CTL) && wdata[BIT_FCLR]));
  // R2: power-down bits move only on a write cycle
  p_pdn_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(phy_pdn));
endmodule

// File: rtl/txctl_regs.sv
module txctl_regs
  import txc_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int ADDR_PDN = 0,
  parameter int ADDR_CTL = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              ctl_ack,
  output logic [1:0]        phy_pdn,
  output logic              tx_reset,
  output logic              rand_reset,
  output logic              tx_enable,
  output logic              late_enable,
  output logic              ctl_req,
  output logic              tx_abort,
  output logic              fifo_rd_rewind,
  output logic              fifo_clr
);
  logic cpu_rst_n, tx_rst_n;
  logic abort_busy, abort_start;
  lvl_t lvl;

  txc_rst_sync #(.STAGES(2)) u_rst_cpu (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(cpu_rst_n)
  );
  txc_rst_sync #(.STAGES(2)) u_rst_tx (
    .clk(tx_clk), .rst_n(rst_n), .rst_n_sync(tx_rst_n)
  );

  txc_cpu_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ADDR_PDN(ADDR_PDN), .ADDR_CTL(ADDR_CTL)
  ) u_regs (
    .clk(clk), .rst_n(cpu_rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ctl_ack(ctl_ack), .abort_busy(abort_busy),
    .abort_start(abort_start), .phy_pdn(phy_pdn), .lvl(lvl), .ctl_req(ctl_req),
    .fifo_rd_rewind(fifo_rd_rewind), .fifo_clr(fifo_clr)
  );

  txc_abort_xfer u_abort (
    .clk(clk), .rst_n(cpu_rst_n), .tx_clk(tx_clk), .tx_rst_n(tx_rst_n),
    .start(abort_start), .busy(abort_busy), .tx_abort(tx_abort)
  );

  assign tx_reset    = lvl.txrst;
  assign rand_reset  = lvl.rndrst;
  assign tx_enable   = lvl.txen && !lvl.txrst;
  assign late_enable = lvl.late;
endmodule

// File: tb/txctl_regs_tb.sv
module txctl_regs_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TX_HALF    = 13;

  logic        clk = 0, tx_clk = 0, rst_n = 0;
  logic        wr_en = 0, ctl_ack = 0;
  logic [3:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [1:0]  phy_pdn;
  logic tx_reset, rand_reset, tx_enable, late_enable, ctl_req, tx_abort;
  logic fifo_rd_rewind, fifo_clr;

  int checks = 0, fails = 0;
  int ab_pulses = 0, ab_len = 0, ab_run = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always #(TX_HALF) tx_clk = ~tx_clk;

  txctl_regs u_dut (
    .clk(clk), .rst_n(rst_n), .tx_clk(tx_clk), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ctl_ack(ctl_ack), .phy_pdn(phy_pdn),
    .tx_reset(tx_reset), .rand_reset(rand_reset), .tx_enable(tx_enable),
    .late_enable(late_enable), .ctl_req(ctl_req), .tx_abort(tx_abort),
    .fifo_rd_rewind(fifo_rd_rewind), .fifo_clr(fifo_clr)
  );

  // Abort pulse monitor in the transmit domain
  always @(negedge tx_clk) begin
    if (tx_abort) ab_run++;
    else if (ab_run != 0) begin
      ab_len = ab_run;
      ab_pulses++;
      ab_run = 0;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0; wdata = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  function automatic logic [31:0] lvl_word(int v);
    return {16'h0, v[3] ? 1'b1 : 1'b0, v[2] ? 1'b1 : 1'b0, 8'h0,
            v[1] ? 1'b1 : 1'b0, v[0] ? 1'b1 : 1'b0, 4'h0};
  endfunction

  function automatic logic [5:0] outs();
    return {tx_reset, rand_reset, tx_enable, late_enable, fifo_rd_rewind, fifo_clr};
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int p0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (6) @(negedge clk);

    // R1: reset state
    rd(4'd0, r); chk("R1 pdn read", r, 32'h2);
    rd(4'd1, r); chk("R1 ctl read", r, 32'h0);
    chk("R1 phy_pdn", {30'h0, phy_pdn}, 32'h2);
    chk("R1 outputs", {26'h0, outs(), ctl_req, tx_abort}, 32'h0);

    // R2: all power-down values, upper write bits ignored
    for (int v = 0; v < 4; v++) begin
      wr(4'd0, 32'hFFFF_FFFC | v);
      chk("R2 phy_pdn", {30'h0, phy_pdn}, v);
      rd(4'd0, r); chk("R2 readback", r, v);
    end

    // R3 and R9: all level combinations, self-clearing bits written as 0
    for (int v = 0; v < 16; v++) begin
      wr(4'd1, lvl_word(v));
      chk("R3 tx_reset",    tx_reset,    v[3]);
      chk("R3 rand_reset",  rand_reset,  v[2]);
      chk("R3 tx_enable",   tx_enable,   v[1] & ~v[3]);
      chk("R3 late_enable", late_enable, v[0]);
      rd(4'd1, r); chk("R3 readback", r, lvl_word(v));
      chk("R9 no action", {ctl_req, fifo_rd_rewind, fifo_clr}, 3'b000);
    end

    // R4: control-frame request held until acknowledge
    wr(4'd1, 32'h0000_0028);
    chk("R4 req raised", ctl_req, 1);
    repeat (3) @(negedge clk);
    chk("R4 req held", ctl_req, 1);
    rd(4'd1, r); chk("R4 readback pending", r, 32'h0000_0028);
    // R9: writing 0 to bit 3 leaves request pending
    wr(4'd1, 32'h0000_0020);
    chk("R9 req kept", ctl_req, 1);
    ctl_ack = 1;
    @(negedge clk);
    ctl_ack = 0;
    chk("R4 req cleared", ctl_req, 0);
    rd(4'd1, r); chk("R4 readback clear", r, 32'h0000_0020);

    // R5: one abort of two transmit clocks
    p0 = ab_pulses;
    wr(4'd1, 32'h0000_0004);
    rd(4'd1, r); chk("R5 pending bit", r[2], 1);
    repeat (60) @(negedge clk);
    chk("R5 pulse count", ab_pulses - p0, 1);
    chk("R5 pulse length", ab_len, 2);
    rd(4'd1, r); chk("R5 pending cleared", r[2], 0);

    // R6: second write while pending is dropped
    p0 = ab_pulses;
    wr(4'd1, 32'h0000_0004);
    wr(4'd1, 32'h0000_0004);
    repeat (60) @(negedge clk);
    chk("R6 single pulse", ab_pulses - p0, 1);
    chk("R6 pulse length", ab_len, 2);

    // R7: FIFO strobes, every combination
    for (int v = 0; v < 4; v++) begin
      wr(4'd1, v);
      chk("R7 strobes high", {fifo_rd_rewind, fifo_clr}, v);
      rd(4'd1, r); chk("R7 readback", r[1:0], v);
      @(negedge clk);
      chk("R7 strobes low", {fifo_rd_rewind, fifo_clr}, 0);
    end

    // R8: unmapped address
    wr(4'd0, 32'h1);
    wr(4'd1, 32'h0000_8010);
    wr(4'd7, 32'hFFFF_FFFF);
    rd(4'd7, r); chk("R8 unmapped read", r, 0);
    chk("R8 phy_pdn kept", {30'h0, phy_pdn}, 32'h1);
    chk("R8 levels kept", {26'h0, outs()}, {26'h0, 6'b100100});
    chk("R8 no req", {ctl_req, tx_abort}, 0);
    rd(4'd1, r); chk("R8 ctl kept", r, 32'h0000_8010);

    done = 1;
    summary();
    $finish;
  end
endmodule